// File: doc/BRIEF.md
# Bus Idle Gap Timer

This block decides when a transmitter may drive the start bit of a new frame on a shared single-wire bus. The bus has to stay idle for a set interval before a new frame begins. The block times that interval in half nominal bit periods. The time base is a one-cycle `half_tick` pulse, supplied from outside, that arrives once per half bit period. When the full interval has passed with the bus idle throughout, the block raises `may_start`. The transmit engine uses that level as a qualifier before it starts a frame.

A 3-bit setting chooses the wait. A nonzero value `n` asks for `n - 0.5` bit periods, which is `2n - 1` half-bit counts. The value zero selects one of three fixed protocol waits instead. Which one applies depends on whether the next frame is a retry, comes from a new initiator, or is the next frame of the same initiator.

The timer can be started in two ways, selected by `auto_start`:
- manually, by the software start-of-message strobe;
- automatically, by the end of any transmitted or received frame.

The block also records, at each start-of-message strobe, whether the end-of-message marker was already set. When it was, the first byte of the frame is also its last byte.

Top module: `idle_gap_timer`

## Requirements
- R1: While reset is held and on the first cycle after it, `may_start` and `sole_byte` are 0.
- R2: With a nonzero `gap_sel` = n captured at arming, `may_start` stays 0 through the first 2n-2 counted ticks and becomes 1 in the cycle after the (2n-1)-th counted tick. A counted tick is a cycle in which `half_tick` = 1 and `bus_idle` = 1.
- R3: With `gap_sel` = 0 at arming, the wait is 6 counted ticks when `retry_flag` = 1. Otherwise it is 10 when `new_init` = 1, and 14 when both flags are 0. `retry_flag` takes priority over `new_init`.
- R4: With `auto_start` = 0, only a `som_req` pulse arms the timer. `tx_end` and `rx_end` pulses neither arm it nor restart it.
- R5: With `auto_start` = 1, a `tx_end` or `rx_end` pulse arms the timer. `som_req` neither arms it nor restarts it.
- R6: A cycle with `bus_idle` = 0 while the timer is counting or ready discards the progress and makes `may_start` 0 from the next cycle. Counting then resumes from zero toward the same wait, and a `half_tick` in that same cycle is not counted.
- R7: An arm event while the timer is counting or ready restarts it from zero, using the setting and flags present at that event. `may_start` is 0 from the next cycle.
- R8: While `enable` = 0, the timer holds no progress, `may_start` is 0 from the next cycle, and all strobes and pulses are ignored.
- R9: `gap_sel`, `retry_flag` and `new_init` are sampled only at the arm event. Later changes do not alter the wait in progress.
- R10: On each `som_req` while enabled, `sole_byte` takes the value `eom_flag` has in that same cycle. `eom_flag` may rise earlier or in the same cycle. `sole_byte` is cleared while `enable` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Block enable; low clears the timer |
| half_tick | input | 1 | One-cycle pulse per half nominal bit period |
| gap_sel | input | SEL_W | Wait setting; 0 selects protocol waits |
| auto_start | input | 1 | 1: arm on frame end; 0: arm on `som_req` |
| som_req | input | 1 | Software start-of-message strobe |
| eom_flag | input | 1 | End-of-message marker level |
| tx_end | input | 1 | End-of-transmitted-frame pulse |
| rx_end | input | 1 | End-of-received-frame pulse |
| retry_flag | input | 1 | Next frame is a retry after a failure |
| new_init | input | 1 | Next frame comes from a new initiator |
| bus_idle | input | 1 | Bus line level (1 = released/idle) |
| may_start | output | 1 | The idle interval has elapsed; a start bit may be driven |
| sole_byte | output | 1 | The frame requested last has a single byte |

## Verification
The bench goes after the edges of each wait:
- It counts one tick short of the wait and then exactly to it. A design that used `2n` or `2n+1` half counts, or whose default waits were off by one, would raise `may_start` a tick late or early.
- It pulls the bus low mid-count, with a tick in the same cycle, and also after the ready point. A timer that only paused, or that counted the coincident tick, would finish early.
- It sends end pulses in manual mode and `som_req` in automatic mode, and it changes the setting during a wait. Either of those would otherwise restart the timer or stretch the running wait.
- It raises `som_req` in the same cycle as `eom_flag`. A design that sampled the marker one cycle late would report a multi-byte frame.

// File: rtl/idle_gap_pkg.sv
package idle_gap_pkg;

  typedef enum logic [1:0] {
    GAP_OFF   = 2'd0,
    GAP_COUNT = 2'd1,
    GAP_READY = 2'd2
  } gap_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/idle_gap_target.sv
module idle_gap_target #(
  parameter int unsigned SEL_W          = 3,
  parameter int unsigned CNT_W          = 4,
  parameter int unsigned RETRY_HALVES   = 6,
  parameter int unsigned NEWINIT_HALVES = 10,
  parameter int unsigned NEXT_HALVES    = 14
) (
  input  logic [SEL_W-1:0] gap_sel,
  input  logic             retry_flag,
  input  logic             new_init,
  output logic [CNT_W-1:0] halves
);

  logic [SEL_W:0] doubled;

  assign doubled = {gap_sel, 1'b0};

  always_comb begin
    if (gap_sel != '0) begin
      halves = CNT_W'(doubled - (SEL_W+1)'(1));
    end else if (retry_flag) begin
      halves = CNT_W'(RETRY_HALVES);
    end else if (new_init) begin
      halves = CNT_W'(NEWINIT_HALVES);
    end else begin
      halves = CNT_W'(NEXT_HALVES);
    end
  end

  always_comb begin
    if (gap_sel != '0) begin
      a_r2_odd_halves: assert (halves[0] == 1'b1);
    end
  end

endmodule

// File: rtl/idle_gap_arm.sv
module idle_gap_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic auto_start,
  input  logic som_req,
  input  logic eom_flag,
  input  logic tx_end,
  input  logic rx_end,
  output logic arm,
  output logic sole_byte
);

  logic frame_end;

  assign frame_end = tx_end | rx_end;
  assign arm       = enable & (auto_start ? frame_end : som_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sole_byte <= 1'b0;
    end else if (!enable) begin
      sole_byte <= 1'b0;
    end else if (som_req) begin
      sole_byte <= eom_flag;
    end
  end

  a_r10_sole_follows_marker: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && som_req) |=> (sole_byte == $past(eom_flag)));

endmodule

// File: rtl/idle_gap_counter.sv
module idle_gap_counter
  import idle_gap_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             arm,
  input  logic [CNT_W-1:0] target,
  input  logic             half_tick,
  input  logic             bus_idle,
  output logic             may_start
);

  gap_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] tgt_q;
  logic [CNT_W-1:0] cnt_nx;

  assign cnt_nx    = cnt + CNT_W'(1);
  assign may_start = (state == GAP_READY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= GAP_OFF;
      cnt   <= '0;
      tgt_q <= '0;
    end else if (!enable) begin
      state <= GAP_OFF;
      cnt   <= '0;
    end else if (arm) begin
      state <= GAP_COUNT;
      cnt   <= '0;
      tgt_q <= target;
    end else if (state != GAP_OFF && !bus_idle) begin
      state <= GAP_COUNT;
      cnt   <= '0;
    end else if (state == GAP_COUNT && half_tick) begin
      if (cnt_nx >= tgt_q) begin
        state <= GAP_READY;
        cnt   <= '0;
      end else begin
        cnt <= cnt_nx;
      end
    end
  end

  a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (state == GAP_COUNT) |-> (cnt < tgt_q));

  a_r2_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(may_start) |-> $past(half_tick && bus_idle));

  a_r6_bus_low_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !bus_idle) |=> !may_start);

  a_r7_arm_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (!may_start && cnt == '0));

  a_r8_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!may_start && cnt == '0));

endmodule

// File: rtl/idle_gap_timer.sv
module idle_gap_timer
  import idle_gap_pkg::*;
#(
  parameter int unsigned SEL_W          = 3,
  parameter int unsigned RETRY_HALVES   = 6,
  parameter int unsigned NEWINIT_HALVES = 10,
  parameter int unsigned NEXT_HALVES    = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             half_tick,
  input  logic [SEL_W-1:0] gap_sel,
  input  logic             auto_start,
  input  logic             som_req,
  input  logic             eom_flag,
  input  logic             tx_end,
  input  logic             rx_end,
  input  logic             retry_flag,
  input  logic             new_init,
  input  logic             bus_idle,
  output logic             may_start,
  output logic             sole_byte
);

  localparam int unsigned SEL_MAX_HALVES = 2 * ((1 << SEL_W) - 1) - 1;
  localparam int unsigned DEF_MAX_HALVES =
    max2(RETRY_HALVES, max2(NEWINIT_HALVES, NEXT_HALVES));
  localparam int unsigned MAX_HALVES = max2(SEL_MAX_HALVES, DEF_MAX_HALVES);
  localparam int unsigned CNT_W      = $clog2(MAX_HALVES + 1);

  logic [CNT_W-1:0] target;
  logic             arm;

  idle_gap_target #(
    .SEL_W         (SEL_W),
    .CNT_W         (CNT_W),
    .RETRY_HALVES  (RETRY_HALVES),
    .NEWINIT_HALVES(NEWINIT_HALVES),
    .NEXT_HALVES   (NEXT_HALVES)
  ) u_target (
    .gap_sel   (gap_sel),
    .retry_flag(retry_flag),
    .new_init  (new_init),
    .halves    (target)
  );

  idle_gap_arm u_arm (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .auto_start(auto_start),
    .som_req   (som_req),
    .eom_flag  (eom_flag),
    .tx_end    (tx_end),
    .rx_end    (rx_end),
    .arm       (arm),
    .sole_byte (sole_byte)
  );

  idle_gap_counter #(
    .CNT_W(CNT_W)
  ) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .arm      (arm),
    .target   (target),
    .half_tick(half_tick),
    .bus_idle (bus_idle),
    .may_start(may_start)
  );

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!may_start && !sole_byte));

endmodule

// File: tb/test_idle_gap_timer.sv
module test_idle_gap_timer;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       half_tick = 1'b0;
  logic [2:0] gap_sel = 3'd0;
  logic       auto_start = 1'b0;
  logic       som_req = 1'b0;
  logic       eom_flag = 1'b0;
  logic       tx_end = 1'b0;
  logic       rx_end = 1'b0;
  logic       retry_flag = 1'b0;
  logic       new_init = 1'b0;
  logic       bus_idle = 1'b1;
  logic       may_start;
  logic       sole_byte;

  int    total = 0;
  int    bad = 0;
  string cur_req = "R1";

  int m_state = 0;
  int m_cnt = 0;
  int m_tgt = 0;
  int m_sole = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idle_gap_timer i_idle_gap_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .half_tick(half_tick),
    .gap_sel(gap_sel), .auto_start(auto_start), .som_req(som_req),
    .eom_flag(eom_flag), .tx_end(tx_end), .rx_end(rx_end),
    .retry_flag(retry_flag), .new_init(new_init), .bus_idle(bus_idle),
    .may_start(may_start), .sole_byte(sole_byte)
  );

  function automatic int wait_halves(input int sel, input bit rt, input bit ni);
    if (sel != 0) return 2 * sel - 1;
    if (rt) return 6;
    if (ni) return 10;
    return 14;
  endfunction

  // reference model: 0 off, 1 counting, 2 ready
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state <= 0; m_cnt <= 0; m_tgt <= 0; m_sole <= 0;
    end else if (!enable) begin
      m_state <= 0; m_cnt <= 0; m_sole <= 0;
    end else begin
      if (som_req) m_sole <= eom_flag;
      if (auto_start ? (tx_end || rx_end) : som_req) begin
        m_state <= 1; m_cnt <= 0;
        m_tgt <= wait_halves(gap_sel, retry_flag, new_init);
      end else if (m_state != 0 && !bus_idle) begin
        m_state <= 1; m_cnt <= 0;
      end else if (m_state == 1 && half_tick) begin
        if (m_cnt + 1 >= m_tgt) begin m_state <= 2; m_cnt <= 0; end
        else m_cnt <= m_cnt + 1;
      end
    end
  end

  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n) begin
      total++;
      if (may_start !== (m_state == 2) || sole_byte !== (m_sole != 0)) begin
        bad++;
        $display("FAIL %s model: may_start=%0b exp=%0b sole_byte=%0b exp=%0b",
                 cur_req, may_start, (m_state == 2), sole_byte, (m_sole != 0));
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) half_tick = 1'b1;
      @(negedge clk) half_tick = 1'b0;
    end
  endtask

  task automatic pulse_som();
    @(negedge clk) som_req = 1'b1;
    @(negedge clk) som_req = 1'b0;
  endtask

  task automatic pulse_tx();
    @(negedge clk) tx_end = 1'b1;
    @(negedge clk) tx_end = 1'b0;
  endtask

  task automatic pulse_rx();
    @(negedge clk) rx_end = 1'b1;
    @(negedge clk) rx_end = 1'b0;
  endtask

  task automatic bus_low_once(input bit with_tick);
    @(negedge clk) begin bus_idle = 1'b0; half_tick = with_tick; end
    @(negedge clk) begin bus_idle = 1'b1; half_tick = 1'b0; end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    enable = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    chk(may_start, 1'b0, "R1", "may_start after reset");
    chk(sole_byte, 1'b0, "R1", "sole_byte after reset");

    // R2: odd half counts for nonzero settings
    cur_req = "R2";
    gap_sel = 3'd1; pulse_som();
    chk(may_start, 1'b0, "R2", "sel1 before tick");
    tick(1);
    chk(may_start, 1'b1, "R2", "sel1 after 1 tick");
    gap_sel = 3'd7; pulse_som();
    tick(12);
    chk(may_start, 1'b0, "R2", "sel7 after 12 ticks");
    tick(1);
    chk(may_start, 1'b1, "R2", "sel7 after 13 ticks");
    gap_sel = 3'd4; pulse_som();
    tick(6);
    chk(may_start, 1'b0, "R2", "sel4 after 6 ticks");
    tick(1);
    chk(may_start, 1'b1, "R2", "sel4 after 7 ticks");

    // R3: default waits
    cur_req = "R3";
    gap_sel = 3'd0; retry_flag = 1'b1; new_init = 1'b1; pulse_som();
    tick(5);
    chk(may_start, 1'b0, "R3", "retry after 5");
    tick(1);
    chk(may_start, 1'b1, "R3", "retry after 6");
    retry_flag = 1'b0; pulse_som();
    tick(9);
    chk(may_start, 1'b0, "R3", "new initiator after 9");
    tick(1);
    chk(may_start, 1'b1, "R3", "new initiator after 10");
    new_init = 1'b0; pulse_som();
    tick(13);
    chk(may_start, 1'b0, "R3", "next frame after 13");
    tick(1);
    chk(may_start, 1'b1, "R3", "next frame after 14");

    // R8: disable clears and ignores events
    cur_req = "R8";
    @(negedge clk) enable = 1'b0;
    @(negedge clk);
    chk(may_start, 1'b0, "R8", "cleared by disable");
    gap_sel = 3'd1; pulse_som();
    enable = 1'b1;
    tick(3);
    chk(may_start, 1'b0, "R8", "som while disabled ignored");

    // R4: manual mode ignores frame ends
    cur_req = "R4";
    pulse_tx(); pulse_rx();
    tick(20);
    chk(may_start, 1'b0, "R4", "frame ends do not arm");
    pulse_som(); tick(1);
    chk(may_start, 1'b1, "R4", "som arms");
    gap_sel = 3'd2; pulse_tx();
    chk(may_start, 1'b1, "R4", "tx_end does not restart");

    // R5: auto mode
    cur_req = "R5";
    @(negedge clk) enable = 1'b0;
    @(negedge clk) begin enable = 1'b1; auto_start = 1'b1; end
    pulse_som(); tick(20);
    chk(may_start, 1'b0, "R5", "som does not arm in auto");
    gap_sel = 3'd2; pulse_rx(); tick(2);
    chk(may_start, 1'b0, "R5", "rx_end armed, 2 ticks");
    tick(1);
    chk(may_start, 1'b1, "R5", "rx_end armed, 3 ticks");
    pulse_som();
    chk(may_start, 1'b1, "R5", "som does not restart in auto");
    gap_sel = 3'd1; pulse_tx();
    chk(may_start, 1'b0, "R5", "tx_end restarts");
    tick(1);
    chk(may_start, 1'b1, "R5", "tx_end armed, 1 tick");

    // R6: bus activity restarts the count
    cur_req = "R6";
    auto_start = 1'b0; gap_sel = 3'd3; pulse_som();
    tick(3);
    bus_low_once(1'b1);
    chk(may_start, 1'b0, "R6", "after bus low mid-count");
    tick(4);
    chk(may_start, 1'b0, "R6", "4 ticks after restart");
    tick(1);
    chk(may_start, 1'b1, "R6", "5 ticks after restart");
    bus_low_once(1'b0);
    chk(may_start, 1'b0, "R6", "bus low after ready");
    tick(4);
    chk(may_start, 1'b0, "R6", "recount 4");
    tick(1);
    chk(may_start, 1'b1, "R6", "recount 5");

    // R7: re-arm restarts with new setting
    cur_req = "R7";
    gap_sel = 3'd3; pulse_som(); tick(3);
    gap_sel = 3'd1; pulse_som();
    chk(may_start, 1'b0, "R7", "re-armed");
    tick(1);
    chk(may_start, 1'b1, "R7", "new wait of 1 tick");

    // R9: setting latched at arm
    cur_req = "R9";
    gap_sel = 3'd2; pulse_som();
    gap_sel = 3'd7; retry_flag = 1'b1;
    tick(2);
    chk(may_start, 1'b0, "R9", "latched wait, 2 ticks");
    tick(1);
    chk(may_start, 1'b1, "R9", "latched wait, 3 ticks");
    retry_flag = 1'b0;

    // R10: single-byte marker
    cur_req = "R10";
    @(negedge clk) begin eom_flag = 1'b1; som_req = 1'b1; end
    @(negedge clk) som_req = 1'b0;
    chk(sole_byte, 1'b1, "R10", "marker with som same cycle");
    eom_flag = 1'b0; pulse_som();
    chk(sole_byte, 1'b0, "R10", "no marker");
    @(negedge clk) eom_flag = 1'b1;
    pulse_som();
    chk(sole_byte, 1'b1, "R10", "marker set earlier");
    @(negedge clk) enable = 1'b0;
    @(negedge clk) enable = 1'b1;
    chk(sole_byte, 1'b0, "R10", "cleared by disable");
    eom_flag = 1'b0;

    repeat (3) @(negedge clk);
    finish_up();
  end

endmodule